// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block watches an externally supplied 16-bit free-running count and compares it against five programmable 16-bit compare values. Software loads each compare value through a byte-wide write port, one byte at a time. A shared enable byte selects which channels may report, and a shared flag byte records which enabled channels have seen their value come up on the count.

The comparison runs only when the counter signals an advance through `count_adv`. On that cycle every enabled channel whose stored value equals `count` sets its flag. The flags stay set until software clears them by writing ones into the flag byte. A single interrupt request is raised while any channel has both its flag and its enable bit set. The block does not drive any pins and does not hold the counter itself.

Top module: `occ_unit`

## Requirements
- R1: Channel n (1..5) stores its compare value in two byte registers. The high byte is at write address 2(n-1) and the low byte at 2(n-1)+1. The enable byte is at address 10 and the flag byte at address 11.
- R2: Channel n owns bit 8-n of both the enable byte and the flag byte, so channel 1 uses bit 7 and channel 5 uses bit 3. Flag bits 2:0 are always 0.
- R3: When `count_adv` is high, `count` equals an enabled channel's compare value, and no reset occurs, that channel's flag bit is 1 on `flags` after the next rising clock edge.
- R4: A channel whose enable bit is 0 never sets its flag, even when its compare value equals `count` on an advance.
- R5: No flag sets in a cycle where `count_adv` is low, even when `count` matches an enabled channel.
- R6: Writing the flag byte clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R7: `irq` is 1 exactly when some flag bit and the same enable bit are both 1. Disabling a channel drops its request but keeps its flag.
- R8: Reset sets every compare value to 0xFFFF and clears the enable byte and the flag byte.
- R9: When a flag-clear write and a new match for the same channel happen in one cycle, the flag ends up set.
- R10: A write to a compare byte or to the enable byte is used by the comparison on every advance after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| count | input | 16 | Free-running count value |
| count_adv | input | 1 | Count has advanced; compare this cycle |
| flags | output | 8 | Match flag byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds a matching count with no advance strobe. A design that compares every cycle would set a flag there. It disables a matching channel, which a design that ignores the enable byte would flag. It also drops an enable while the flag is still set: a design that clears flags on disable, or that raises the request from flags alone, is caught by that step. Two cases target wrong behaviour on clears and reset. A clear that lands in the same cycle as a new match catches a design where the clear wins. Matching on 0xFFFF right after reset catches compare registers that reset to zero.

// File: rtl/occ_unit.sv
module occ_unit #(
  parameter int NUM_CH = 5,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [15:0]   count,
  input  logic          count_adv,
  output logic [7:0]    flags,
  output logic          irq
);

  localparam int LSB = 8 - NUM_CH;
  localparam logic [AW-1:0] EN_ADDR   = AW'(2 * NUM_CH);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(2 * NUM_CH + 1);
  localparam logic [7:0] CH_MASK = 8'(((1 << NUM_CH) - 1) << LSB);

  logic [7:0] en_q;
  logic [7:0] flag_q;
  logic [7:0] hit;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    if (g >= LSB) begin : g_ch
      localparam logic [AW-1:0] HI_ADDR = AW'(2 * (7 - g));
      localparam logic [AW-1:0] LO_ADDR = AW'(2 * (7 - g) + 1);
      logic [15:0] cmp_q;
      always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 16'hFFFF;
        else if (wr_en && wr_addr == HI_ADDR) cmp_q[15:8] <= wr_data;
        else if (wr_en && wr_addr == LO_ADDR) cmp_q[7:0]  <= wr_data;
      end
      assign hit[g] = en_q[g] && (cmp_q == count);
    end else begin : g_none
      assign hit[g] = 1'b0;
    end
  end

  wire en_wr   = wr_en && wr_addr == EN_ADDR;
  wire flag_wr = wr_en && wr_addr == FLAG_ADDR;
  wire [7:0] clr = flag_wr ? (wr_data & CH_MASK) : 8'h00;
  wire [7:0] set = count_adv ? hit : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 8'h00;
      flag_q <= 8'h00;
    end else begin
      if (en_wr) en_q <= wr_data & CH_MASK;
      flag_q <= (flag_q & ~clr) | set;
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & en_q);

endmodule

// File: rtl/occ_unit_chk.sv
module occ_unit_chk #(
  parameter int NUM_CH = 5,
  parameter int AW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          count_adv,
  input logic [7:0]    flags,
  input logic          irq,
  input logic [7:0]    en_q
);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(2 * NUM_CH + 1);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  AST_SET_NEEDS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(count_adv) |-> ((flags & ~$past(flags)) == 8'h00)); // R5

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((flags & ~$past(flags) & ~$past(en_q)) == 8'h00)); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_en && wr_addr == FLAG_ADDR && !count_adv)
      |-> ((flags & $past(wr_data)) == 8'h00)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wr_en) |-> (($past(flags) & ~flags) == 8'h00)); // R6

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 8'h00)); // R7

  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (flags[7-NUM_CH:0] == '0)); // R2
endmodule

bind occ_unit occ_unit_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .count_adv(count_adv), .flags(flags), .irq(irq),
  .en_q(en_q)
);

// File: tb/sim_occ_unit.sv
module sim_occ_unit;
  localparam int PERIOD = 10;
  localparam int NV = 29;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count = '0;
  logic        count_adv = 1'b0;
  logic [7:0]  flags;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  occ_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .count_adv(count_adv),
    .flags(flags), .irq(irq)
  );

  // {req[3:0], kind[1:0], addr[3:0], data[7:0], count[15:0], exp_flags[7:0], exp_irq}
  // kind: 0 write, 1 advance, 2 idle (count held, no advance), 3 advance with write
  localparam logic [42:0] VEC [NV] = '{
    {4'd1, 2'd0, 4'h0, 8'h12, 16'h0000, 8'h00, 1'b0},
    {4'd1, 2'd0, 4'h1, 8'h34, 16'h0000, 8'h00, 1'b0},
    {4'd1, 2'd0, 4'hA, 8'h80, 16'h0000, 8'h00, 1'b0},
    {4'd3, 2'd1, 4'h0, 8'h00, 16'h1233, 8'h00, 1'b0},
    {4'd3, 2'd1, 4'h0, 8'h00, 16'h1234, 8'h80, 1'b1},
    {4'd6, 2'd0, 4'hB, 8'h80, 16'h0000, 8'h00, 1'b0},
    {4'd5, 2'd2, 4'h0, 8'h00, 16'h1234, 8'h00, 1'b0},
    {4'd5, 2'd2, 4'h0, 8'h00, 16'h1234, 8'h00, 1'b0},
    {4'd1, 2'd0, 4'h2, 8'h00, 16'h0000, 8'h00, 1'b0},
    {4'd1, 2'd0, 4'h3, 8'h10, 16'h0000, 8'h00, 1'b0},
    {4'd4, 2'd1, 4'h0, 8'h00, 16'h0010, 8'h00, 1'b0},
    {4'd10,2'd0, 4'hA, 8'hC0, 16'h0000, 8'h00, 1'b0},
    {4'd2, 2'd1, 4'h0, 8'h00, 16'h0010, 8'h40, 1'b1},
    {4'd6, 2'd0, 4'hB, 8'h00, 16'h0000, 8'h40, 1'b1},
    {4'd1, 2'd0, 4'h8, 8'hAB, 16'h0000, 8'h40, 1'b1},
    {4'd1, 2'd0, 4'h9, 8'hCD, 16'h0000, 8'h40, 1'b1},
    {4'd1, 2'd0, 4'hA, 8'hC8, 16'h0000, 8'h40, 1'b1},
    {4'd2, 2'd1, 4'h0, 8'h00, 16'hABCD, 8'h48, 1'b1},
    {4'd6, 2'd0, 4'hB, 8'h48, 16'h0000, 8'h00, 1'b0},
    {4'd1, 2'd0, 4'hA, 8'h30, 16'h0000, 8'h00, 1'b0},
    {4'd8, 2'd1, 4'h0, 8'h00, 16'hFFFF, 8'h30, 1'b1},
    {4'd7, 2'd0, 4'hA, 8'h00, 16'h0000, 8'h30, 1'b0},
    {4'd6, 2'd0, 4'hB, 8'h30, 16'h0000, 8'h00, 1'b0},
    {4'd10,2'd0, 4'h0, 8'h56, 16'h0000, 8'h00, 1'b0},
    {4'd1, 2'd0, 4'hA, 8'h80, 16'h0000, 8'h00, 1'b0},
    {4'd10,2'd1, 4'h0, 8'h00, 16'h5634, 8'h80, 1'b1},
    {4'd9, 2'd3, 4'hB, 8'h80, 16'h5634, 8'h80, 1'b1},
    {4'd6, 2'd0, 4'hB, 8'h80, 16'h0000, 8'h00, 1'b0},
    {4'd10,2'd1, 4'h0, 8'h00, 16'h1234, 8'h00, 1'b0}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] ef, input logic ei);
    checks++;
    if (flags !== ef || irq !== ei) begin
      fails++;
      $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b", req, flags, irq, ef, ei);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                      input logic [15:0] c, input logic adv);
    wr_en = we; wr_addr = a; wr_data = d; count = c; count_adv = adv;
    @(negedge clk);
    wr_en = 1'b0; count_adv = 1'b0;
  endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R8", 8'h00, 1'b0);
    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      case (v[38:37])
        2'd0: step(1'b1, v[36:33], v[32:25], v[24:9], 1'b0);
        2'd1: step(1'b0, v[36:33], v[32:25], v[24:9], 1'b1);
        2'd2: step(1'b0, v[36:33], v[32:25], v[24:9], 1'b0);
        default: step(1'b1, v[36:33], v[32:25], v[24:9], 1'b1);
      endcase
      check(req_name(v[42:39]), v[8:1], v[0]);
    end
    // R8: reset restores compare values and clears enables and flags
    step(1'b1, 4'hA, 8'hF8, 16'h0, 1'b0);
    step(1'b0, 4'h0, 8'h00, 16'h5634, 1'b1);
    check("R8", 8'h80, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R8", 8'h00, 1'b0);
    step(1'b0, 4'h0, 8'h00, 16'hFFFF, 1'b1);
    check("R4", 8'h00, 1'b0);
    step(1'b1, 4'hA, 8'hFF, 16'h0, 1'b0);
    step(1'b0, 4'h0, 8'h00, 16'hFFFF, 1'b1);
    check("R8", 8'hF8, 1'b1);
    // R2: writing low bits to the flag byte does not disturb channel flags
    step(1'b1, 4'hB, 8'h07, 16'h0, 1'b0);
    check("R2", 8'hF8, 1'b1);
    step(1'b1, 4'hB, 8'hFF, 16'h0, 1'b0);
    check("R6", 8'h00, 1'b0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule